// File: doc/BRIEF.md
# Slice-Pipelined Unsigned Adder

This block adds two unsigned operands plus a carry-in at full clock rate by cutting the carry path into fixed-width slices. Each slice is added in its own pipeline stage, and the carry leaving a slice is registered before the next more significant slice consumes it. The clock period is therefore set by one narrow slice add and a register, not by a carry rippling across the whole word. The cost is latency and extra registers; making the word wider adds stages but does not slow the add rate.

To line the slices up, the operand bits of slice k pass through k skew registers before they reach their adder, so they arrive in the same cycle as the registered carry from slice k-1. Each finished sum slice then passes through deskew registers so that every slice of one result, and the final carry, leave together. With the default 18-bit width and 6-bit slices there are three stages.

Operands enter on a valid/ready stream and results leave on another. The whole pipeline advances on a single enable, which is high whenever the output register is empty or is being taken. Holding `out_ready` low with a result waiting freezes every stage and drops `in_ready`; operands presented while `in_ready` is low are not taken. With `out_ready` held high a new pair is taken on every clock. `WIDTH` must be a whole multiple of `SLICE_W`.

Top module: `slice_pipe_adder`

## Requirements
- R1: For every accepted pair, `out_sum` equals (`in_a` + `in_b` + `in_carry`) mod 2^WIDTH and `out_carry` equals bit WIDTH of that full sum.
- R2: With `out_ready` held high, a result is presented with `out_valid` high after exactly S rising edges counted from (and including) the edge that accepts its operands, where S = WIDTH/SLICE_W (3 by default).
- R3: While `out_ready` is high, `in_ready` stays high and an operand pair is accepted on every clock; no more than S results are ever in flight.
- R4: After reset `out_valid` is low and `in_ready` is high.
- R5: When `out_valid` is high and `out_ready` is low, on the next cycle `out_valid` is still high and `out_sum` and `out_carry` are unchanged.
- R6: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low; operands offered with `in_valid` high in such a cycle are not taken and produce no result.
- R7: A carry generated in any slice reaches every more significant slice and `out_carry` (e.g. all ones plus carry-in 1 gives sum 0 and carry 1; 0x3F + 1 gives 0x40; 0xFFF + carry-in gives 0x1000).
- R8: Results leave in acceptance order, each exactly once; cycles with `in_valid` low produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair and carry-in are presented |
| in_ready | output | 1 | Block takes the pair on this edge if `in_valid` is high |
| in_a | input | WIDTH | First unsigned operand |
| in_b | input | WIDTH | Second unsigned operand |
| in_carry | input | 1 | Carry into the least significant slice |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_sum | output | WIDTH | Sum bits of the result |
| out_carry | output | 1 | Carry out of the most significant slice |

## Verification
The hardest situation to reach is a stall that freezes results whose slices are still in different stages, with fresh operands pushing on the input, because only then would a mistimed skew or deskew register mix slices of two different results. The stimulus reaches it by toggling `out_ready` at random while `in_valid` is also random, so the pipeline is frozen at every fill level with junk operands offered at the input, and every result is compared against a queue of expected sums. Carry-boundary operands (all ones, 0x3F, 0xFFF, top-bit pairs) run back to back so that slices of neighbouring results sit in adjacent stages together.

// File: rtl/spa_pkg.sv
package spa_pkg;
  // Number of slice stages for a given word and slice width.
  function automatic int unsigned stage_count(input int unsigned width,
                                              input int unsigned slice_w);
    return width / slice_w;
  endfunction
endpackage

// File: rtl/spa_delay_line.sv
module spa_delay_line #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] tap [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      tap[0] <= d;
      for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
    end
  end

  assign q = tap[DEPTH-1];
endmodule

// File: rtl/spa_slice_add.sv
module spa_slice_add #(
  parameter int unsigned SW = 6
) (
  input  logic          clk,
  input  logic          en,
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          ci,
  output logic [SW-1:0] s,
  output logic          co
);
  logic [SW:0] total;

  assign total = {1'b0, a} + {1'b0, b} + {{SW{1'b0}}, ci};

  always_ff @(posedge clk) begin
    if (en) begin
      s  <= total[SW-1:0];
      co <= total[SW];
    end
  end
endmodule

// File: rtl/spa_valid_pipe.sv
module spa_valid_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic vin,
  output logic vout
);
  logic [DEPTH-1:0] stage_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_v <= '0;
    end else if (en) begin
      stage_v[0] <= vin;
      for (int i = 1; i < DEPTH; i++) stage_v[i] <= stage_v[i-1];
    end
  end

  assign vout = stage_v[DEPTH-1];

  // R4
  valid_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stage_v == '0));
endmodule

// File: rtl/slice_pipe_adder.sv
module slice_pipe_adder #(
  parameter int unsigned WIDTH   = 18,
  parameter int unsigned SLICE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_carry,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_carry
);
  localparam int unsigned S     = spa_pkg::stage_count(WIDTH, SLICE_W);
  localparam int unsigned OCC_W = $clog2(S + 2);

  logic       adv;
  logic [S:1] cy;

  // One enable for every stage: move when the output slot is free or taken.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  spa_valid_pipe #(.DEPTH(S)) u_vpipe (
    .clk  (clk),
    .rst  (rst),
    .en   (adv),
    .vin  (in_valid),
    .vout (out_valid)
  );

  for (genvar k = 0; k < S; k++) begin : g_slice
    logic [SLICE_W-1:0] a_k;
    logic [SLICE_W-1:0] b_k;
    logic               ci_k;
    logic [SLICE_W-1:0] s_k;
    logic [SLICE_W-1:0] s_al;

    if (k == 0) begin : g_head
      assign a_k  = in_a[SLICE_W-1:0];
      assign b_k  = in_b[SLICE_W-1:0];
      assign ci_k = in_carry;
    end else begin : g_skew
      logic [2*SLICE_W-1:0] ab_d;
      spa_delay_line #(.WIDTH(2*SLICE_W), .DEPTH(k)) u_skew (
        .clk (clk),
        .en  (adv),
        .d   ({in_b[k*SLICE_W +: SLICE_W], in_a[k*SLICE_W +: SLICE_W]}),
        .q   (ab_d)
      );
      assign a_k  = ab_d[SLICE_W-1:0];
      assign b_k  = ab_d[2*SLICE_W-1:SLICE_W];
      assign ci_k = cy[k];
    end

    spa_slice_add #(.SW(SLICE_W)) u_add (
      .clk (clk),
      .en  (adv),
      .a   (a_k),
      .b   (b_k),
      .ci  (ci_k),
      .s   (s_k),
      .co  (cy[k+1])
    );

    if (k == S - 1) begin : g_last
      assign s_al = s_k;
    end else begin : g_deskew
      spa_delay_line #(.WIDTH(SLICE_W), .DEPTH(S - 1 - k)) u_deskew (
        .clk (clk),
        .en  (adv),
        .d   (s_k),
        .q   (s_al)
      );
    end

    assign out_sum[k*SLICE_W +: SLICE_W] = s_al;
  end

  assign out_carry = cy[S];

  // Occupancy tracker used only by the checks below.
  logic [OCC_W-1:0] occ;
  logic             fire_in;
  logic             fire_out;
  assign fire_in  = in_valid && in_ready;
  assign fire_out = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else if (fire_in && !fire_out) occ <= occ + 1'b1;
    else if (!fire_in && fire_out) occ <= occ - 1'b1;
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_carry)));

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(S));

  // R8
  out_backed_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (occ != '0));

  // R6
  frozen_input_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> out_valid);
endmodule

// File: tb/slice_pipe_adder_tb_top.sv
module slice_pipe_adder_tb_top;
  localparam int unsigned W          = 18;
  localparam int unsigned SW         = 6;
  localparam int unsigned S          = W / SW;
  localparam int          CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_carry = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_sum;
  logic         out_carry;

  slice_pipe_adder #(.WIDTH(W), .SLICE_W(SW)) dut_i (
    .clk, .rst, .in_valid, .in_ready, .in_a, .in_b, .in_carry,
    .out_valid, .out_ready, .out_sum, .out_carry
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [W-1:0] sum;
    logic         c;
    int           cyc;
    bit           lat;
    string        tag;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0;
  int     fails  = 0;
  int     cyc    = 0;
  int     n_in   = 0;
  int     n_out  = 0;
  bit     lat_phase = 1'b1;
  bit     held = 1'b0;
  logic [W-1:0] held_sum;
  logic         held_c;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Driver and monitor in one cycle step: drive at negedge, sample after.
  task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic ci, input bit rdy, input string tag);
    logic [W:0] full;
    exp_t e;
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_carry = ci; out_ready = rdy;
    #1;
    // R6: ready relation at the ports
    check(in_ready == !(out_valid && !out_ready), "R6", "in_ready",
          longint'(in_ready), longint'(!(out_valid && !out_ready)));
    if (held) begin
      // R5: held result must stay put
      check(out_valid && out_sum == held_sum && out_carry == held_c, "R5",
            "held result", {out_valid, out_carry, out_sum}, {1'b1, held_c, held_sum});
    end
    if (in_valid && in_ready) begin
      full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      e.sum = full[W-1:0];
      e.c   = full[W];
      e.cyc = cyc;
      e.lat = lat_phase;
      e.tag = tag;
      sb.push_back(e);
      n_in++;
    end
    if (out_valid && out_ready) begin
      n_out++;
      if (sb.size() == 0) begin
        check(1'b0, "R8", "unexpected result", longint'(out_sum), 0);
      end else begin
        e = sb.pop_front();
        check(out_sum == e.sum && out_carry == e.c, e.tag, "sum/carry",
              {out_carry, out_sum}, {e.c, e.sum});
        if (e.lat)
          check(cyc - e.cyc == S, "R2", "latency", longint'(cyc - e.cyc), longint'(S));
      end
    end
    held = out_valid && !out_ready;
    held_sum = out_sum;
    held_c = out_carry;
  endtask

  function automatic logic [W-1:0] rnd();
    logic [63:0] r;
    r = {$urandom, $urandom};
    return r[W-1:0];
  endfunction

  task automatic drain();
    for (int i = 0; i < S + 3; i++) step(1'b0, '0, '0, 1'b0, 1'b1, "R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R4
    check(out_valid == 1'b0, "R4", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R4", "in_ready after reset", longint'(in_ready), 1);

    // R7 / R1: carry boundary cases, back to back, ready held high
    step(1'b1, '0, '0, 1'b0, 1'b1, "R1");
    step(1'b1, '1, '1, 1'b1, 1'b1, "R7");
    step(1'b1, '1, '0, 1'b1, 1'b1, "R7");
    step(1'b1, W'(18'h0003F), W'(18'h00001), 1'b0, 1'b1, "R7");
    step(1'b1, W'(18'h00FFF), '0, 1'b1, 1'b1, "R7");
    step(1'b1, W'(18'h20000), W'(18'h20000), 1'b0, 1'b1, "R7");
    step(1'b1, W'(18'h00FC0), W'(18'h00040), 1'b0, 1'b1, "R7");
    // R3: in_ready must remain high through a long back-to-back burst
    for (int i = 0; i < 40; i++) begin
      step(1'b1, rnd(), rnd(), 1'($urandom), 1'b1, "R1");
      check(in_ready == 1'b1, "R3", "in_ready during burst", longint'(in_ready), 1);
    end
    drain();

    // R8: bubbles in the input stream
    for (int i = 0; i < 40; i++)
      step(1'(($urandom % 3) != 0), rnd(), rnd(), 1'($urandom), 1'b1, "R8");
    drain();

    // R5 / R6: random back-pressure with junk offered while frozen
    lat_phase = 1'b0;
    for (int i = 0; i < 300; i++)
      step(1'($urandom), rnd(), rnd(), 1'($urandom), 1'($urandom), "R1");
    drain();

    // R8: every accepted pair produced exactly one result
    check(sb.size() == 0, "R8", "leftover expected", longint'(sb.size()), 0);
    check(n_in == n_out, "R8", "results vs accepted", longint'(n_out), longint'(n_in));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule